// File: doc/BRIEF.md
# Flag-Addressed Microcode Control Sequencer

This block is the control unit of a small single-bus accumulator CPU. Each cycle it forms a table address from four pieces: a 4-bit step counter, the 4-bit opcode held in the instruction register, the zero flag and the carry flag. A combinational microcode table turns that address into a 16-bit control word. The datapath uses the control word to pick bus drivers, load registers, select ALU subtraction, advance or load the program counter, and halt.

The flags are part of the table address. A conditional jump therefore needs no separate branch logic: the same opcode reads a different entry, with jump controls or without them, depending on the flag. The step counter moves on the falling clock edge, and the datapath captures on the rising edge, so the control word is settled half a cycle before each capture. The table is read a second time at the next step. When that next entry is empty, the counter returns to 0 at once and no idle cycle is spent between instructions.

Top module: `ucode_sequencer`

## Requirements
- R1: While `rst_n` is low, the step counter is held at 0 and `ctrl` shows the first fetch word 0x4004, including across falling edges.
- R2: Every opcode starts with two fetch steps: step 0 gives 0x4004 (program counter onto bus, address register load) and step 1 gives 0x1408 (memory onto bus, instruction register load, counter increment).
- R3: Opcode 1 (load A) follows the fetch with 0x4800 and then 0x1200.
- R4: Opcode 2 (add) follows the fetch with 0x4800, 0x1020 and 0x0280. Opcode 3 (subtract) gives the same sequence, but its last word is 0x02C0, which adds the subtract bit 6.
- R5: Opcode 4 (store) gives 0x4800 then 0x2100. Opcode 5 (load immediate) gives 0x0A00. Opcode 14 (output) gives 0x0110.
- R6: Opcode 6 (jump) gives the single execute word 0x0802 (operand onto bus plus jump, bit 1).
- R7: Opcode 7 gives 0x0802 after the fetch only when the zero flag is 1. With zero flag 0 it has no execute step, whatever the carry flag is.
- R8: Opcode 8 gives 0x0802 after the fetch only when the carry flag is 1. With carry flag 0 it has no execute step, whatever the zero flag is.
- R9: Opcode 15 gives 0x8000 (halt, bit 15) after the fetch. The step after it is 0.
- R10: In the cycle after an instruction's last non-empty step, `ctrl` shows 0x4004 again. No all-zero control word is ever shown between instructions.
- R11: Opcode 0 and the unassigned opcodes 9 to 13 run only the two fetch steps and then restart.
- R12: Bit 0 of `ctrl` is always 0. At most one of the five bus-driver bits is set in any word. These are bit 12 (memory out), bit 11 (operand out), bit 8 (A out), bit 7 (ALU out) and bit 2 (counter out).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock. The step counter moves on its falling edge. |
| rst_n | input | 1 | Asynchronous active-low reset of the step counter. |
| opcode | input | 4 | Opcode field of the current instruction. |
| flag_c | input | 1 | Carry flag from the datapath. |
| flag_z | input | 1 | Zero flag from the datapath. |
| ctrl | output | 16 | Control word: bit 15 halt down to bit 1 jump. Bit 0 is 0. |

## Verification
The assertions assume that `opcode`, `flag_c` and `flag_z` do not change between the rising edge that loads the instruction register and the falling edge that ends the instruction. The restart decision and the halt check both read these inputs across that window. The bench therefore changes them only while the step counter sits at 0, just after a rising edge. The step-0 entry and the step-1 lookahead entry do not depend on the opcode or the flags, so a change at that point cannot disturb the sequence.

// File: rtl/ucode_seq_pkg.sv
package ucode_seq_pkg;

   // Control word layout (bit positions are decoded by the datapath)
   localparam int CW_BITS   = 16;
   localparam int B_HALT    = 15;
   localparam int B_MAR_LD  = 14;
   localparam int B_MEM_WR  = 13;
   localparam int B_MEM_OE  = 12;
   localparam int B_OPR_OE  = 11;
   localparam int B_IR_LD   = 10;
   localparam int B_ACC_LD  = 9;
   localparam int B_ACC_OE  = 8;
   localparam int B_ALU_OE  = 7;
   localparam int B_ALU_SUB = 6;
   localparam int B_TMP_LD  = 5;
   localparam int B_DSP_LD  = 4;
   localparam int B_PC_INC  = 3;
   localparam int B_PC_OE   = 2;
   localparam int B_PC_LD   = 1;

   typedef logic [CW_BITS-1:0] ctrl_t;

   function automatic ctrl_t cbit(input int pos);
      ctrl_t v;
      v = '0;
      v[pos] = 1'b1;
      return v;
   endfunction

   // Named microcode words
   localparam ctrl_t W_FETCH_A  = cbit(B_PC_OE)  | cbit(B_MAR_LD);
   localparam ctrl_t W_FETCH_B  = cbit(B_MEM_OE) | cbit(B_IR_LD) | cbit(B_PC_INC);
   localparam ctrl_t W_OPR_ADDR = cbit(B_OPR_OE) | cbit(B_MAR_LD);
   localparam ctrl_t W_MEM_ACC  = cbit(B_MEM_OE) | cbit(B_ACC_LD);
   localparam ctrl_t W_MEM_TMP  = cbit(B_MEM_OE) | cbit(B_TMP_LD);
   localparam ctrl_t W_SUM_ACC  = cbit(B_ALU_OE) | cbit(B_ACC_LD);
   localparam ctrl_t W_DIF_ACC  = W_SUM_ACC | cbit(B_ALU_SUB);
   localparam ctrl_t W_ACC_MEM  = cbit(B_ACC_OE) | cbit(B_MEM_WR);
   localparam ctrl_t W_OPR_ACC  = cbit(B_OPR_OE) | cbit(B_ACC_LD);
   localparam ctrl_t W_BRANCH   = cbit(B_OPR_OE) | cbit(B_PC_LD);
   localparam ctrl_t W_ACC_DSP  = cbit(B_ACC_OE) | cbit(B_DSP_LD);
   localparam ctrl_t W_STOP     = cbit(B_HALT);

   typedef enum logic [3:0] {
      OPC_NOP  = 4'd0,
      OPC_LDA  = 4'd1,
      OPC_ADD  = 4'd2,
      OPC_SUB  = 4'd3,
      OPC_STA  = 4'd4,
      OPC_LDI  = 4'd5,
      OPC_JMP  = 4'd6,
      OPC_JZ   = 4'd7,
      OPC_JC   = 4'd8,
      OPC_OUT  = 4'd14,
      OPC_HLT  = 4'd15
   } opc_e;

endpackage

// File: rtl/ucode_table.sv
module ucode_table
   import ucode_seq_pkg::*;
#(
   parameter int STEP_W = 4,
   parameter int OP_W   = 4,
   localparam int ADDR_W = STEP_W + OP_W + 2
) (
   input  logic [ADDR_W-1:0] addr,
   output ctrl_t             word
);

   // Address fields: step lowest, then opcode, then zero, then carry on top
   logic [STEP_W-1:0] f_step;
   logic [OP_W-1:0]   f_op;
   logic              f_z;
   logic              f_c;

   assign f_step = addr[STEP_W-1:0];
   assign f_op   = addr[STEP_W +: OP_W];
   assign f_z    = addr[STEP_W+OP_W];
   assign f_c    = addr[STEP_W+OP_W+1];

   logic [3:0] op4;
   generate
      if (OP_W >= 4) begin : g_op_trim
         assign op4 = f_op[3:0];
      end else begin : g_op_pad
         assign op4 = {{(4-OP_W){1'b0}}, f_op};
      end
   endgenerate

   // Execute step index, counted from the first step after the fetch
   logic [STEP_W-1:0] x_step;
   assign x_step = f_step - STEP_W'(2);

   always_comb begin
      word = '0;
      if (f_step == STEP_W'(0)) begin
         word = W_FETCH_A;
      end else if (f_step == STEP_W'(1)) begin
         word = W_FETCH_B;
      end else begin
         unique case (op4)
            OPC_LDA: begin
               if (x_step == STEP_W'(0)) word = W_OPR_ADDR;
               else if (x_step == STEP_W'(1)) word = W_MEM_ACC;
            end
            OPC_ADD: begin
               if (x_step == STEP_W'(0)) word = W_OPR_ADDR;
               else if (x_step == STEP_W'(1)) word = W_MEM_TMP;
               else if (x_step == STEP_W'(2)) word = W_SUM_ACC;
            end
            OPC_SUB: begin
               if (x_step == STEP_W'(0)) word = W_OPR_ADDR;
               else if (x_step == STEP_W'(1)) word = W_MEM_TMP;
               else if (x_step == STEP_W'(2)) word = W_DIF_ACC;
            end
            OPC_STA: begin
               if (x_step == STEP_W'(0)) word = W_OPR_ADDR;
               else if (x_step == STEP_W'(1)) word = W_ACC_MEM;
            end
            OPC_LDI: begin
               if (x_step == STEP_W'(0)) word = W_OPR_ACC;
            end
            OPC_JMP: begin
               if (x_step == STEP_W'(0)) word = W_BRANCH;
            end
            OPC_JZ: begin
               if (x_step == STEP_W'(0) && f_z) word = W_BRANCH;
            end
            OPC_JC: begin
               if (x_step == STEP_W'(0) && f_c) word = W_BRANCH;
            end
            OPC_OUT: begin
               if (x_step == STEP_W'(0)) word = W_ACC_DSP;
            end
            OPC_HLT: begin
               if (x_step == STEP_W'(0)) word = W_STOP;
            end
            default: word = '0;
         endcase
      end
   end

endmodule

// File: rtl/ucode_restart.sv
module ucode_restart
   import ucode_seq_pkg::*;
#(
   parameter int STEP_W        = 4,
   parameter bit EARLY_RESTART = 1'b1
) (
   input  ctrl_t             cur_word,
   input  ctrl_t             nxt_word,
   input  logic [STEP_W-1:0] step,
   output logic              restart
);

   logic at_top;
   assign at_top = &step;

   generate
      if (EARLY_RESTART) begin : g_lookahead
         // Stop after the last busy step: no idle cycle between instructions
         assign restart = (cur_word == '0) || (nxt_word == '0) || at_top;
      end else begin : g_on_empty
         // Stop on the first empty step: costs one idle cycle
         logic unused_nxt;
         assign unused_nxt = |nxt_word;
         assign restart = (cur_word == '0) || at_top;
      end
   endgenerate

endmodule

// File: rtl/ucode_step_ctr.sv
module ucode_step_ctr #(
   parameter int STEP_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   output logic [STEP_W-1:0] step
);

   // Falling-edge counter: control settles half a cycle before datapath capture
   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n)     step <= '0;
      else if (clear) step <= '0;
      else            step <= step + STEP_W'(1);
   end

   // R10: a restart request returns the counter to the first fetch step
   assert_clear_to_zero_R10: assert property (@(negedge clk) disable iff (!rst_n)
      clear |=> (step == '0));

   // R10: without a restart the counter moves exactly one step
   assert_single_advance_R10: assert property (@(negedge clk) disable iff (!rst_n)
      !clear |=> (step == STEP_W'($past(step) + STEP_W'(1))));

endmodule

// File: rtl/ucode_sequencer.sv
module ucode_sequencer
   import ucode_seq_pkg::*;
#(
   parameter int STEP_W        = 4,
   parameter int OP_W          = 4,
   parameter bit EARLY_RESTART = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [OP_W-1:0] opcode,
   input  logic            flag_c,
   input  logic            flag_z,
   output logic [15:0]     ctrl
);

   localparam int ADDR_W = STEP_W + OP_W + 2;

   initial begin
      assert (STEP_W >= 3 && STEP_W <= 8)
         else $fatal(1, "ucode_sequencer: STEP_W must hold five steps");
      assert (OP_W == 4)
         else $fatal(1, "ucode_sequencer: opcode field must be 4 bits");
      assert (CW_BITS == 16)
         else $fatal(1, "ucode_sequencer: control word must be 16 bits");
   end

   logic [STEP_W-1:0] step;
   logic [STEP_W-1:0] step_nxt;
   logic [ADDR_W-1:0] addr_cur;
   logic [ADDR_W-1:0] addr_nxt;
   ctrl_t             word_cur;
   ctrl_t             word_nxt;
   logic              restart;

   assign step_nxt = step + STEP_W'(1);
   assign addr_cur = {flag_c, flag_z, opcode, step};
   assign addr_nxt = {flag_c, flag_z, opcode, step_nxt};

   ucode_table #(.STEP_W(STEP_W), .OP_W(OP_W)) u_tbl_cur (
      .addr (addr_cur),
      .word (word_cur)
   );

   generate
      if (EARLY_RESTART) begin : g_peek
         ucode_table #(.STEP_W(STEP_W), .OP_W(OP_W)) u_tbl_nxt (
            .addr (addr_nxt),
            .word (word_nxt)
         );
      end else begin : g_no_peek
         logic [ADDR_W-1:0] unused_addr;
         assign unused_addr = addr_nxt;
         assign word_nxt = '1;
      end
   endgenerate

   ucode_restart #(.STEP_W(STEP_W), .EARLY_RESTART(EARLY_RESTART)) u_rst (
      .cur_word (word_cur),
      .nxt_word (word_nxt),
      .step     (step),
      .restart  (restart)
   );

   ucode_step_ctr #(.STEP_W(STEP_W)) u_ctr (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (restart),
      .step  (step)
   );

   assign ctrl = word_cur;

   // R12: never two drivers on the shared bus
   assert_one_bus_driver_R12: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ctrl[B_MEM_OE], ctrl[B_OPR_OE], ctrl[B_ACC_OE], ctrl[B_ALU_OE], ctrl[B_PC_OE]}));

   // R7: the jump on zero loads the program counter only with the zero flag set
   assert_jz_needs_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (opcode == OPC_JZ && ctrl[B_PC_LD]) |-> flag_z);

   // R8: the jump on carry loads the program counter only with the carry flag set
   assert_jc_needs_carry_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (opcode == OPC_JC && ctrl[B_PC_LD]) |-> flag_c);

   // R9: halt is the last step of its instruction
   assert_halt_then_fetch_R9: assert property (@(negedge clk) disable iff (!rst_n)
      ctrl[B_HALT] |=> (step == '0));

   // R2: the first step of every instruction is the opcode-free fetch
   assert_fetch_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (step == '0) |-> (ctrl[B_PC_OE] && ctrl[B_MAR_LD]));

endmodule

// File: tb/ucode_sequencer_test.sv
module ucode_sequencer_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  opcode = 4'd0;
   logic        flag_c = 1'b0;
   logic        flag_z = 1'b0;
   logic [15:0] ctrl;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   localparam logic [15:0] F0 = 16'h4004;
   localparam logic [15:0] F1 = 16'h1408;

   always #5 clk = ~clk;

   ucode_sequencer uut (
      .clk    (clk),
      .rst_n  (rst_n),
      .opcode (opcode),
      .flag_c (flag_c),
      .flag_z (flag_z),
      .ctrl   (ctrl)
   );

   task automatic chk(input string req, input logic [15:0] exp);
      logic [4:0] drv;
      checks++;
      if (ctrl !== exp) begin
         failures++;
         $display("FAIL %s ctrl actual=%h expected=%h t=%0t", req, ctrl, exp, $time);
      end
      // R12: spare bit and single bus driver on every sampled word
      drv = {ctrl[12], ctrl[11], ctrl[8], ctrl[7], ctrl[2]};
      checks++;
      if (ctrl[0] !== 1'b0 || $countones(drv) > 1) begin
         failures++;
         $display("FAIL R12 ctrl actual=%h expected bit0=0, drivers<=1", ctrl);
      end
   endtask

   // Run one instruction from the step-0 window; expect fetch, execute words, then fetch again
   task automatic run_instr(input string req, input logic [3:0] op, input logic c,
                            input logic z, input logic [15:0] ex [4], input int n);
      opcode = op;
      flag_c = c;
      flag_z = z;
      #1;
      chk("R2", F0);
      @(posedge clk); #1;
      chk("R2", F1);
      for (int i = 0; i < n; i++) begin
         @(posedge clk); #1;
         chk(req, ex[i]);
      end
      @(posedge clk); #1;
      chk("R10", F0);
   endtask

   task automatic t_reset;
      rst_n = 1'b0;
      @(posedge clk); #1;
      chk("R1", F0);
      @(negedge clk); #1;
      chk("R1", F0);
      @(posedge clk); #1;
      rst_n = 1'b1;
      chk("R1", F0);
   endtask

   task automatic t_loads;
      logic [15:0] ex [4];
      ex = '{16'h4800, 16'h1200, 16'h0, 16'h0};
      run_instr("R3", 4'd1, 1'b0, 1'b0, ex, 2);
      ex = '{16'h4800, 16'h2100, 16'h0, 16'h0};
      run_instr("R5", 4'd4, 1'b1, 1'b0, ex, 2);
      ex = '{16'h0A00, 16'h0, 16'h0, 16'h0};
      run_instr("R5", 4'd5, 1'b0, 1'b1, ex, 1);
      ex = '{16'h0110, 16'h0, 16'h0, 16'h0};
      run_instr("R5", 4'd14, 1'b1, 1'b1, ex, 1);
   endtask

   task automatic t_arith;
      logic [15:0] ex [4];
      ex = '{16'h4800, 16'h1020, 16'h0280, 16'h0};
      run_instr("R4", 4'd2, 1'b0, 1'b0, ex, 3);
      ex = '{16'h4800, 16'h1020, 16'h02C0, 16'h0};
      run_instr("R4", 4'd3, 1'b1, 1'b1, ex, 3);
   endtask

   task automatic t_jumps;
      logic [15:0] ex [4];
      ex = '{16'h0802, 16'h0, 16'h0, 16'h0};
      run_instr("R6", 4'd6, 1'b0, 1'b0, ex, 1);
      run_instr("R7", 4'd7, 1'b0, 1'b1, ex, 1);
      run_instr("R7", 4'd7, 1'b1, 1'b1, ex, 1);
      run_instr("R7", 4'd7, 1'b1, 1'b0, ex, 0);
      run_instr("R7", 4'd7, 1'b0, 1'b0, ex, 0);
      run_instr("R8", 4'd8, 1'b1, 1'b0, ex, 1);
      run_instr("R8", 4'd8, 1'b1, 1'b1, ex, 1);
      run_instr("R8", 4'd8, 1'b0, 1'b1, ex, 0);
      run_instr("R8", 4'd8, 1'b0, 1'b0, ex, 0);
   endtask

   task automatic t_idle_ops;
      logic [15:0] ex [4];
      ex = '{16'h0, 16'h0, 16'h0, 16'h0};
      run_instr("R11", 4'd0, 1'b0, 1'b0, ex, 0);
      for (int op = 9; op <= 13; op++)
         run_instr("R11", 4'(op), 1'b1, 1'b1, ex, 0);
   endtask

   task automatic t_halt;
      logic [15:0] ex [4];
      ex = '{16'h8000, 16'h0, 16'h0, 16'h0};
      run_instr("R9", 4'd15, 1'b0, 1'b0, ex, 1);
   endtask

   initial begin
      t_reset();
      t_loads();
      t_arith();
      t_jumps();
      t_idle_ops();
      t_halt();
      // R10: back-to-back instructions with different lengths
      t_arith();
      t_loads();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog run did not complete");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule